// File: doc/BRIEF.md
# Operand Effective Address Generator for an 8-bit Processor Core

This unit turns the addressing mode of a decoded instruction, its operand bytes, the current program counter and the two index registers into the 16-bit address of the operand. For relative branches it returns the sign-extended branch offset instead. Pointer-based modes need one or two bytes from memory. The unit fetches these itself through a simple synchronous byte-read port, low byte first.

A request is presented on `req_valid` together with the mode and operands. It is taken only while the unit is not busy. The unit pulses `done` for one cycle when the address is ready and holds the result until the next pulse. It also reports whether an indexed addition moved the address into another 256-byte page, and it marks modes that carry no memory address. Decode, operand data transfer and execution are handled by neighbouring logic.

Top module: `eff_addr_unit`

## Requirements
- R1: During and directly after synchronous active-low reset, `done`, `busy`, `rd_en`, `page_cross` and `no_addr` are 0 and `ea` is 0x0000.
- R2: Mode codes on `req_mode` are: 0 none, 1 immediate, 2 zero page, 3 zero page+X, 4 zero page+Y, 5 absolute, 6 absolute+X, 7 absolute+Y, 8 (zero page+X) pointer, 9 (zero page) pointer+Y, 10 relative, 11 indirect. Absolute gives `{opnd_hi, opnd_lo}`, immediate gives `pc_in`+1 with 16-bit wrap, and zero page gives `{0x00, opnd_lo}`.
- R3: Zero page+X and zero page+Y give `{0x00, (opnd_lo + index) mod 256}`, so the high byte of `ea` is always 0x00.
- R4: Absolute+X and absolute+Y give `{opnd_hi, opnd_lo}` + index with 16-bit wrap, and `page_cross` is 1 exactly when the high byte of the sum differs from `opnd_hi`.
- R5: Mode 8 reads the low pointer byte at `{0x00, (opnd_lo + X) mod 256}` and the high byte at the next address modulo 256 within page 0x00. The pointer is the result.
- R6: Mode 9 reads the pointer low byte at `{0x00, opnd_lo}` and the high byte at `{0x00, (opnd_lo + 1) mod 256}`, then adds Y with 16-bit wrap. `page_cross` is 1 when the addition changes the pointer's high byte.
- R7: Mode 11 reads the target low byte at `{opnd_hi, opnd_lo}` and the high byte at `{opnd_hi, (opnd_lo + 1) mod 256}`, so a pointer ending in 0xFF wraps within its own page.
- R8: Relative mode returns `opnd_lo` sign-extended to 16 bits (0x80 gives 0xFF80, 0x7F gives 0x007F).
- R9: Mode 0 and the unused codes 12 to 15 produce `no_addr`=1, `ea`=0x0000, `page_cross`=0 and issue no reads; every other mode produces `no_addr`=0.
- R10: `done` is high for exactly one cycle. It rises one clock after the accepting edge for modes without pointer reads and three clocks after it for modes 8, 9 and 11. `ea`, `page_cross` and `no_addr` change only together with a `done` pulse.
- R11: `busy` is 1 from the accepting edge until the result is registered, and a request presented while `busy` is 1 is ignored.
- R12: Read data arrives on `rd_data` the cycle after `rd_en`. Pointer modes issue exactly two reads, low byte address first; other modes issue none, and only pointer modes ever raise `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_mode | input | 4 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| pc_in | input | 16 | Program counter of the instruction |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| busy | output | 1 | Request in progress |
| rd_en | output | 1 | Pointer byte read strobe |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address or sign-extended offset |
| page_cross | output | 1 | Indexed addition changed the high byte |
| no_addr | output | 1 | Mode carries no memory address |

## Verification
The assertions check on every cycle that `done` never lasts two cycles and that the result outputs stay put between pulses. They also check that pointer reads in the zero-page modes stay in page zero, that the second indirect-jump read stays in the page of the first, and that reads and page crossings come only from the modes allowed to make them. Only the bench scenarios show the address values themselves. These are the wrap cases at 0xFF and 0xFFFF, the pointer arithmetic against a memory model, the latency for each class of mode, and a request dropped while the unit is busy.

// File: rtl/ea_pkg.sv
// Shared types for the effective address generator.
// Assumes a 4-bit mode field decoded upstream; codes above 11 mean "no address".
package ea_pkg;
    typedef enum logic [3:0] {
        AM_NONE = 4'd0,
        AM_IMM  = 4'd1,
        AM_ZPG  = 4'd2,
        AM_ZPX  = 4'd3,
        AM_ZPY  = 4'd4,
        AM_ABS  = 4'd5,
        AM_ABX  = 4'd6,
        AM_ABY  = 4'd7,
        AM_IZX  = 4'd8,
        AM_IZY  = 4'd9,
        AM_REL  = 4'd10,
        AM_IND  = 4'd11
    } mode_t;

    localparam logic [3:0] MODE_LAST = 4'd11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_FIN
    } seq_t;
endpackage

// File: rtl/ea_index_add.sv
// Adds an unsigned index to a base address with wrap at the address width
// and reports whether the page (bits above the index width) changed.
// Assumes IW < W.
module ea_index_add #(
    parameter int W  = 16,
    parameter int IW = 8
) (
    input  logic [W-1:0]  base,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  sum,
    output logic          crossed
);
    // Purpose: wrapped sum and page-change detection.
    always_comb begin
        sum     = base + W'(idx);
        crossed = (sum[W-1:IW] != base[W-1:IW]);
    end
endmodule

// File: rtl/ea_fetch_seq.sv
// Sequencer for one request: idle, optional two pointer reads, final cycle.
// Assumes the read port returns data one cycle after the strobe.
module ea_fetch_seq
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_ptr,
    output logic busy,
    output logic rd_en,
    output logic rd_second,
    output logic cap_lo,
    output logic fin
);
    seq_t state;

    // Purpose: advance through the request phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (start) state <= need_ptr ? ST_PTR_LO : ST_FIN;
                ST_PTR_LO: state <= ST_PTR_HI;
                ST_PTR_HI: state <= ST_FIN;
                ST_FIN:    state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode phase strobes for the datapath.
    always_comb begin
        busy      = (state != ST_IDLE);
        rd_en     = (state == ST_PTR_LO) || (state == ST_PTR_HI);
        rd_second = (state == ST_PTR_HI);
        cap_lo    = (state == ST_PTR_HI);
        fin       = (state == ST_FIN);
    end

    // R12
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_LO) |=> (state == ST_PTR_HI));

    // R11
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_HI) |=> (state == ST_FIN));
endmodule

// File: rtl/eff_addr_unit.sv
// Effective address generator. Captures a request while idle, fetches a
// two-byte pointer for the pointer-based modes, then registers the address,
// page-cross flag and no-address flag with a one-cycle done pulse.
// Assumes DW-bit data and a 2*DW-bit address space.
module eff_addr_unit
    import ea_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_mode,
    input  logic [DW-1:0]     opnd_lo,
    input  logic [DW-1:0]     opnd_hi,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [DW-1:0]     x_in,
    input  logic [DW-1:0]     y_in,
    output logic              busy,
    output logic              rd_en,
    output logic [2*DW-1:0]   rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              done,
    output logic [2*DW-1:0]   ea,
    output logic              page_cross,
    output logic              no_addr
);
    localparam int AW = 2 * DW;
    localparam logic [DW-1:0] ZPAGE = '0;

    mode_t         mode_in, mode_q;
    logic          accept, need_ptr_in, use_x_in;
    logic [DW-1:0] idx_in, zp_sum, lo_q, hi_q, idx_q, plo_q;
    logic [AW-1:0] pc_q, ptr_a_in, ptr_b_in, ptr_a_q, ptr_b_q;
    logic          rd_second, cap_lo, fin;
    logic [AW-1:0] ptr_word, add_base, add_sum;
    logic          add_cross;
    logic [AW-1:0] res_ea;
    logic          res_pc, res_na;

    // Purpose: classify the incoming request and form pointer addresses.
    always_comb begin
        mode_in     = (req_mode > MODE_LAST) ? AM_NONE : mode_t'(req_mode);
        accept      = req_valid && !busy;
        need_ptr_in = (mode_in == AM_IZX) || (mode_in == AM_IZY) || (mode_in == AM_IND);
        use_x_in    = (mode_in == AM_ZPX) || (mode_in == AM_ABX) || (mode_in == AM_IZX);
        idx_in      = use_x_in ? x_in : y_in;
        zp_sum      = opnd_lo + x_in;
        unique case (mode_in)
            AM_IZX: begin
                ptr_a_in = {ZPAGE, zp_sum};
                ptr_b_in = {ZPAGE, DW'(zp_sum + 1'b1)};
            end
            AM_IZY: begin
                ptr_a_in = {ZPAGE, opnd_lo};
                ptr_b_in = {ZPAGE, DW'(opnd_lo + 1'b1)};
            end
            default: begin
                ptr_a_in = {opnd_hi, opnd_lo};
                ptr_b_in = {opnd_hi, DW'(opnd_lo + 1'b1)};
            end
        endcase
    end

    // Purpose: hold the accepted request for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= AM_NONE;
            lo_q    <= '0;
            hi_q    <= '0;
            idx_q   <= '0;
            pc_q    <= '0;
            ptr_a_q <= '0;
            ptr_b_q <= '0;
        end else if (accept) begin
            mode_q  <= mode_in;
            lo_q    <= opnd_lo;
            hi_q    <= opnd_hi;
            idx_q   <= idx_in;
            pc_q    <= pc_in;
            ptr_a_q <= ptr_a_in;
            ptr_b_q <= ptr_b_in;
        end
    end

    ea_fetch_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .need_ptr  (need_ptr_in),
        .busy      (busy),
        .rd_en     (rd_en),
        .rd_second (rd_second),
        .cap_lo    (cap_lo),
        .fin       (fin)
    );

    // Purpose: steer the read port to the first or second pointer byte.
    assign rd_addr = rd_second ? ptr_b_q : ptr_a_q;

    // Purpose: keep the low pointer byte returned by the first read.
    always_ff @(posedge clk) begin
        if (!rst_n)      plo_q <= '0;
        else if (cap_lo) plo_q <= rd_data;
    end

    assign ptr_word = {rd_data, plo_q};
    assign add_base = (mode_q == AM_IZY) ? ptr_word : {hi_q, lo_q};

    ea_index_add #(.W(AW), .IW(DW)) u_add (
        .base    (add_base),
        .idx     (idx_q),
        .sum     (add_sum),
        .crossed (add_cross)
    );

    // Purpose: select the result for the captured mode.
    always_comb begin
        res_ea = '0;
        res_pc = 1'b0;
        res_na = 1'b0;
        unique case (mode_q)
            AM_IMM:                 res_ea = pc_q + 1'b1;
            AM_ZPG:                 res_ea = {ZPAGE, lo_q};
            AM_ZPX, AM_ZPY:         res_ea = {ZPAGE, DW'(lo_q + idx_q)};
            AM_ABS:                 res_ea = {hi_q, lo_q};
            AM_ABX, AM_ABY, AM_IZY: begin
                res_ea = add_sum;
                res_pc = add_cross;
            end
            AM_IZX, AM_IND:         res_ea = ptr_word;
            AM_REL:                 res_ea = {{DW{lo_q[DW-1]}}, lo_q};
            default:                res_na = 1'b1;
        endcase
    end

    // Purpose: register the result and pulse done once per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            ea         <= '0;
            page_cross <= 1'b0;
            no_addr    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                ea         <= res_ea;
                page_cross <= res_pc;
                no_addr    <= res_na;
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ea) && $stable(page_cross) && $stable(no_addr)));

    // R3
    zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_ZPG || mode_q == AM_ZPX || mode_q == AM_ZPY))
            |-> (ea[AW-1:DW] == ZPAGE));

    // R5
    zp_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (mode_q == AM_IZX || mode_q == AM_IZY)) |-> (rd_addr[AW-1:DW] == ZPAGE));

    // R7
    ind_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_second && mode_q == AM_IND)
            |-> (rd_addr[AW-1:DW] == $past(rd_addr[AW-1:DW])));

    // R4
    cross_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && page_cross) |-> (mode_q == AM_ABX || mode_q == AM_ABY || mode_q == AM_IZY));

    // R12
    read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (mode_q == AM_IZX || mode_q == AM_IZY || mode_q == AM_IND));
endmodule

// File: tb/sim_eff_addr_unit.sv
`timescale 1ns/1ps
module sim_eff_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, x_in = '0, y_in = '0;
    logic [15:0] pc_in = '0;
    logic        busy, rd_en, done, page_cross, no_addr;
    logic [15:0] rd_addr, ea;
    logic [7:0]  rd_data = '0;

    int checks = 0;
    int fails  = 0;
    int rd_total = 0;
    logic [15:0] rd_prev = '0, rd_last = '0;

    always #4 clk = ~clk;

    eff_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
        .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .ea(ea), .page_cross(page_cross), .no_addr(no_addr)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29 + a[15:8] * 8'd7 + 8'h3C);
    endfunction

    // Synchronous read memory model: data the cycle after the strobe.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data  <= mem_f(rd_addr);
            rd_prev  <= rd_last;
            rd_last  <= rd_addr;
            rd_total <= rd_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements.
    task automatic model(input logic [3:0] m, input logic [7:0] lo, hi,
                         input logic [15:0] pcv, input logic [7:0] xv, yv,
                         output logic [15:0] e, output logic pcx, output logic na,
                         output int nrd, output logic [15:0] a0, output logic [15:0] a1);
        logic [7:0]  z;
        logic [15:0] b, p;
        e = 16'h0; pcx = 1'b0; na = 1'b0; nrd = 0; a0 = '0; a1 = '0;
        case (m)
            4'd1: e = pcv + 16'd1;
            4'd2: e = {8'h00, lo};
            4'd3: begin z = lo + xv; e = {8'h00, z}; end
            4'd4: begin z = lo + yv; e = {8'h00, z}; end
            4'd5: e = {hi, lo};
            4'd6: begin b = {hi, lo}; e = b + {8'h00, xv}; pcx = (e[15:8] != hi); end
            4'd7: begin b = {hi, lo}; e = b + {8'h00, yv}; pcx = (e[15:8] != hi); end
            4'd8: begin
                z = lo + xv; a0 = {8'h00, z}; z = z + 8'd1; a1 = {8'h00, z};
                e = {mem_f(a1), mem_f(a0)}; nrd = 2;
            end
            4'd9: begin
                z = lo + 8'd1; a0 = {8'h00, lo}; a1 = {8'h00, z};
                p = {mem_f(a1), mem_f(a0)}; e = p + {8'h00, yv};
                pcx = (e[15:8] != p[15:8]); nrd = 2;
            end
            4'd10: e = {{8{lo[7]}}, lo};
            4'd11: begin
                z = lo + 8'd1; a0 = {hi, lo}; a1 = {hi, z};
                e = {mem_f(a1), mem_f(a0)}; nrd = 2;
            end
            default: na = 1'b1;
        endcase
    endtask

    task automatic run_req(input logic [3:0] m, input logic [7:0] lo, hi,
                           input logic [15:0] pcv, input logic [7:0] xv, yv,
                           input string req);
        logic [15:0] e, a0, a1, held;
        logic pcx, na;
        int nrd, base, n;
        model(m, lo, hi, pcv, xv, yv, e, pcx, na, nrd, a0, a1);
        @(negedge clk);
        base = rd_total;
        req_valid = 1'b1; req_mode = m; opnd_lo = lo; opnd_hi = hi;
        pc_in = pcv; x_in = xv; y_in = yv;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == ((nrd == 2) ? 4 : 2), "R10", "latency", n, (nrd == 2) ? 4 : 2);
        chk(ea == e, req, "ea", ea, e);
        chk(page_cross == pcx, req, "page_cross", page_cross, pcx);
        chk(no_addr == na, "R9", "no_addr", no_addr, na);
        chk((rd_total - base) == nrd, "R12", "read count", rd_total - base, nrd);
        if (nrd == 2) begin
            chk(rd_prev == a0, req, "first read addr", rd_prev, a0);
            chk(rd_last == a1, req, "second read addr", rd_last, a1);
        end
        held = ea;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done single pulse", done, 0);
        chk(ea == held, "R10", "ea held", ea, held);
    endtask

    initial begin
        logic [15:0] e, a0, a1;
        logic pcx, na;
        int nrd, n;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 0 && busy == 0 && rd_en == 0, "R1", "strobes in reset",
            {done, busy, rd_en}, 0);
        chk(ea == 16'h0 && page_cross == 0 && no_addr == 0, "R1", "outputs in reset",
            {ea, page_cross, no_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && busy == 0 && ea == 16'h0, "R1", "after reset", ea, 0);

        // Directed corners
        run_req(4'd5, 8'h34, 8'h12, 16'h0400, 8'h00, 8'h00, "R2");
        run_req(4'd1, 8'h00, 8'h00, 16'hFFFF, 8'h00, 8'h00, "R2");
        run_req(4'd2, 8'hAB, 8'hCD, 16'h0000, 8'h00, 8'h00, "R2");
        run_req(4'd3, 8'hF0, 8'h77, 16'h0000, 8'h20, 8'h00, "R3");
        run_req(4'd4, 8'hFF, 8'h77, 16'h0000, 8'h00, 8'hFF, "R3");
        run_req(4'd6, 8'hF0, 8'h12, 16'h0000, 8'h20, 8'h00, "R4");
        run_req(4'd6, 8'hFF, 8'hFF, 16'h0000, 8'h01, 8'h00, "R4");
        run_req(4'd7, 8'h00, 8'h12, 16'h0000, 8'h00, 8'h05, "R4");
        run_req(4'd8, 8'hFF, 8'h00, 16'h0000, 8'h00, 8'h00, "R5");
        run_req(4'd8, 8'hF0, 8'h00, 16'h0000, 8'h0F, 8'h00, "R5");
        run_req(4'd9, 8'hFF, 8'h00, 16'h0000, 8'h00, 8'hF0, "R6");
        run_req(4'd11, 8'hFF, 8'h30, 16'h0000, 8'h00, 8'h00, "R7");
        run_req(4'd11, 8'h10, 8'h30, 16'h0000, 8'h00, 8'h00, "R7");
        run_req(4'd10, 8'h80, 8'h00, 16'h0000, 8'h00, 8'h00, "R8");
        run_req(4'd10, 8'h7F, 8'h00, 16'h0000, 8'h00, 8'h00, "R8");
        run_req(4'd0, 8'h55, 8'h66, 16'h1234, 8'h01, 8'h02, "R9");
        run_req(4'd14, 8'h55, 8'h66, 16'h1234, 8'h01, 8'h02, "R9");

        // R11: request during busy is dropped
        model(4'd11, 8'h40, 8'h22, 16'h0, 8'h0, 8'h0, e, pcx, na, nrd, a0, a1);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 4'd11; opnd_lo = 8'h40; opnd_hi = 8'h22;
        @(negedge clk);
        req_mode = 4'd5; opnd_lo = 8'h11; opnd_hi = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 10) begin @(negedge clk); n++; end
        chk(ea == e, "R11", "busy request ignored", ea, e);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R11", "no second result", done, 0);
        end

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            run_req(m, 8'($urandom), 8'($urandom), 16'($urandom), 8'($urandom),
                    8'($urandom), (m >= 4'd8 && m <= 4'd9) ? "R5_R6_r12" : "R2_R4");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule